// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Bridge

This block is a bus master bridge between an internal single-request port and an external peripheral bus. Some external peripherals take their address and their data over the same pins. The bridge serves these and ordinary peripherals from one shared 16-bit pin bus. The top three bits of the 24-bit request address pick one of eight external areas.

Each of areas 3 to 7 has an enable bit. When the bit is set, accesses to that area run a one-clock address phase with an address-latch strobe on the shared pins, and then a data phase. Areas 0 to 2, and any area whose enable bit is clear, run a plain cycle in which only data uses the shared pins. A per-area width bit selects 8-bit operation, which uses the low byte lane only, or 16-bit operation, which uses both lanes. During every access the whole address also appears on a separate address bus.

The pin bus is presented as split output, output-enable and input signals, so a pad ring can build the bidirectional pins from them. Reads insert one turnaround clock after the address phase and capture the pins on the data strobe clock.

Top module: `mpx_bus_bridge`

## Requirements
- R1: After a synchronous reset, ale, rd_stb, wr_stb, req_ready and pad_oe are all 0, and both configuration registers are cleared.
- R2: The area is req_addr[23:21]. Areas 0, 1 and 2 always run a plain cycle with no ale, even after 1s are written to their enable bits.
- R3: cfg_we with cfg_sel=0 loads the enable register, where bit n enables multiplexed mode for area n (3..7). An access to an enabled area shows exactly one ale clock. An access to a disabled area shows none.
- R4: When width bit n is 0 (8-bit), address bits 7..0 and data bits 7..0 use pad lanes 7..0. pad_oe is 2'b01 and pad_out[15:8] is 0. The width register is loaded by cfg_we with cfg_sel=1.
- R5: When width bit n is 1 (16-bit), address bits 15..0 and data bits 15..0 use all 16 pads, and pad_oe is 2'b11 while driving.
- R6: ext_addr equals the full 24-bit request address during the address phase and the data phase.
- R7: The address phase lasts exactly one clock. ale is 1 in that clock, and pad_out carries the address.
- R8: A multiplexed read has one clock after the address phase in which pad_oe=0 and no strobe is active, before rd_stb rises.
- R9: A write asserts wr_stb for exactly one clock, and in that clock pad_out carries the write data and the pads are driven.
- R10: A read asserts rd_stb for one clock with pad_oe=0. pad_in is sampled at the end of that clock. rsp_rdata returns the 16-bit value, or in 8-bit mode the low byte zero-extended.
- R11: req_ready is high for exactly one clock, the clock after the data phase. rsp_rdata is valid in that clock. A request still held valid during req_ready is not started again.
- R12: The mode and width of an access are fixed from the register values at the clock edge that accepts it. A configuration write at that same edge affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the width register |
| cfg_wdata | input | 8 | One bit per area |
| req_valid | input | 1 | Request valid, held until req_ready |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 24 | Byte address; bits 23..21 select the area |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data |
| ext_addr | output | 24 | Dedicated address bus |
| pad_out | output | 16 | Shared pin output value |
| pad_oe | output | 2 | Output enable per byte lane (bit 0 lanes 7..0, bit 1 lanes 15..8) |
| pad_in | input | 16 | Shared pin input value |
| ale | output | 1 | Address-latch strobe |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |

## Verification
A configuration write and the acceptance of a request can occur at the same clock edge. In that case the new register value must not leak into the access being started. The bench provokes this by raising cfg_we, which clears all enable bits, together with req_valid for an area that is currently multiplexed. The scoreboard computes that access from the old register values, so it must still show ale. The next access to the same area is expected to be a plain cycle.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
    parameter int ADDR_W     = 24;
    parameter int DATA_W     = 16;
    parameter int LANE_W     = 8;
    parameter int AREA_W     = 3;
    parameter int N_AREAS    = 1 << AREA_W;
    parameter int N_LANES    = DATA_W / LANE_W;
    parameter int FIRST_MUX  = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_TURN = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    typedef struct packed {
        logic              write;
        logic              mux;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic logic [AREA_W-1:0] area_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: AREA_W];
    endfunction

    function automatic logic [DATA_W-1:0] lane_fit(input logic wide, input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        r = '0;
        r[LANE_W-1:0] = d[LANE_W-1:0];
        return wide ? d : r;
    endfunction

    function automatic logic [N_LANES-1:0] lane_oe(input logic wide);
        logic [N_LANES-1:0] r;
        r = '0;
        r[0] = 1'b1;
        return wide ? {N_LANES{1'b1}} : r;
    endfunction
endpackage

// File: rtl/mpx_area_cfg.sv
module mpx_area_cfg
    import mpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [N_AREAS-1:0] cfg_wdata,
    output logic [N_AREAS-1:0] mux_en,
    output logic [N_AREAS-1:0] wide_en
);
    for (genvar n = 0; n < N_AREAS; n++) begin : g_area
        if (n < FIRST_MUX) begin : g_plain
            assign mux_en[n] = 1'b0;
        end else begin : g_mux
            always_ff @(posedge clk) begin
                if (rst)                     mux_en[n] <= 1'b0;
                else if (cfg_we && !cfg_sel) mux_en[n] <= cfg_wdata[n];
            end
        end
        always_ff @(posedge clk) begin
            if (rst)                    wide_en[n] <= 1'b0;
            else if (cfg_we && cfg_sel) wide_en[n] <= cfg_wdata[n];
        end
    end

    assert_enable_load_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_sel) |=> mux_en[N_AREAS-1:FIRST_MUX] == $past(cfg_wdata[N_AREAS-1:FIRST_MUX]));
    assert_width_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_sel) |=> $stable(wide_en));
endmodule

// File: rtl/mpx_cycle_fsm.sv
module mpx_cycle_fsm
    import mpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [N_AREAS-1:0] mux_en,
    input  logic [N_AREAS-1:0] wide_en,
    output phase_e             phase,
    output xfer_t              cur,
    output logic               req_ready
);
    phase_e            ph_q, ph_d;
    xfer_t             cur_q;
    logic              ready_q;
    logic              accept;
    logic [AREA_W-1:0] area;

    assign area   = area_of(req_addr);
    assign accept = (ph_q == PH_IDLE) && req_valid && !ready_q;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: if (accept) ph_d = mux_en[area] ? PH_ADDR : PH_DATA;
            PH_ADDR: ph_d = cur_q.write ? PH_DATA : PH_TURN;
            PH_TURN: ph_d = PH_DATA;
            PH_DATA: ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            cur_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            ready_q <= (ph_q == PH_DATA);
            if (accept) begin
                cur_q.write <= req_write;
                cur_q.mux   <= mux_en[area];
                cur_q.wide  <= wide_en[area];
                cur_q.addr  <= req_addr;
                cur_q.wdata <= req_wdata;
            end
        end
    end

    assign phase     = ph_q;
    assign cur       = cur_q;
    assign req_ready = ready_q;

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
        ready_q |=> ph_q == PH_IDLE);
    assert_turn_to_data_R8: assert property (@(posedge clk) disable iff (rst)
        ph_q == PH_TURN |=> ph_q == PH_DATA);
endmodule

// File: rtl/mpx_pin_lanes.sv
module mpx_pin_lanes
    import mpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  phase_e             phase,
    input  xfer_t              cur,
    input  logic [DATA_W-1:0]  pad_in,
    output logic [DATA_W-1:0]  pad_out,
    output logic [N_LANES-1:0] pad_oe,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic               ale,
    output logic               rd_stb,
    output logic               wr_stb,
    output logic [DATA_W-1:0]  rsp_rdata
);
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        pad_out  = '0;
        pad_oe   = '0;
        ale      = 1'b0;
        rd_stb   = 1'b0;
        wr_stb   = 1'b0;
        ext_addr = '0;
        unique case (phase)
            PH_ADDR: begin
                ale      = 1'b1;
                ext_addr = cur.addr;
                pad_out  = lane_fit(cur.wide, cur.addr[DATA_W-1:0]);
                pad_oe   = lane_oe(cur.wide);
            end
            PH_TURN: ext_addr = cur.addr;
            PH_DATA: begin
                ext_addr = cur.addr;
                if (cur.write) begin
                    wr_stb  = 1'b1;
                    pad_out = lane_fit(cur.wide, cur.wdata);
                    pad_oe  = lane_oe(cur.wide);
                end else begin
                    rd_stb = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (rd_stb) rdata_q <= lane_fit(cur.wide, pad_in);
    end

    assign rsp_rdata = rdata_q;

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ale, rd_stb, wr_stb}));
    assert_rd_released_R10: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> pad_oe == '0);
endmodule

// File: rtl/mpx_bus_bridge.sv
module mpx_bus_bridge
    import mpx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic                   cfg_sel,
    input  logic [N_AREAS-1:0]     cfg_wdata,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   req_ready,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [ADDR_W-1:0]      ext_addr,
    output logic [DATA_W-1:0]      pad_out,
    output logic [N_LANES-1:0]     pad_oe,
    input  logic [DATA_W-1:0]      pad_in,
    output logic                   ale,
    output logic                   rd_stb,
    output logic                   wr_stb
);
    logic [N_AREAS-1:0] mux_en;
    logic [N_AREAS-1:0] wide_en;
    phase_e             phase;
    xfer_t              cur;

    mpx_area_cfg u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mux_en(mux_en), .wide_en(wide_en)
    );

    mpx_cycle_fsm u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .mux_en(mux_en),
        .wide_en(wide_en), .phase(phase), .cur(cur), .req_ready(req_ready)
    );

    mpx_pin_lanes u_pins (
        .clk(clk), .rst(rst), .phase(phase), .cur(cur), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .ext_addr(ext_addr), .ale(ale),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .rsp_rdata(rsp_rdata)
    );

    assert_ale_one_clock_R7: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);
    assert_ale_area_R2: assert property (@(posedge clk) disable iff (rst)
        ale |-> area_of(ext_addr) >= AREA_W'(FIRST_MUX));
    assert_turnaround_R8: assert property (@(posedge clk) disable iff (rst)
        (ale && !cur.write) |=> (pad_oe == '0 && !rd_stb && !wr_stb));
    assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);
    assert_narrow_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        ((ale || wr_stb) && !cur.wide) |-> (pad_oe == N_LANES'(1) && pad_out[DATA_W-1:LANE_W] == '0));
endmodule

// File: tb/sim_mpx_bus_bridge.sv
module sim_mpx_bus_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic [15:0] rsp_rdata;
    logic [23:0] ext_addr;
    logic [15:0] pad_out;
    logic [1:0]  pad_oe;
    logic [15:0] pad_in = '0;
    logic        ale, rd_stb, wr_stb;

    always #2 clk = ~clk;

    mpx_bus_bridge u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .ext_addr(ext_addr), .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in),
        .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] en_m = '0, wd_m = '0;

    typedef struct {
        logic        write, mux, wide;
        logic [23:0] addr;
        logic [15:0] wdata, pin;
    } exp_t;
    exp_t q[$];

    function automatic logic [15:0] fit(logic w, logic [15:0] d);
        return w ? d : {8'h00, d[7:0]};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(logic sel, logic [7:0] d);
        @(posedge clk) #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk) #1;
        cfg_we = 1'b0;
        if (sel) wd_m = d; else en_m = d & 8'hF8;
    endtask

    // driver: pushes the expected item, then runs the handshake
    task automatic access(logic w, logic [23:0] a, logic [15:0] wd, logic [15:0] pin,
                          bit with_cfg, logic [7:0] cdat);
        exp_t e;
        e.write = w; e.addr = a; e.wdata = wd; e.pin = pin;
        e.mux  = en_m[a[23:21]];
        e.wide = wd_m[a[23:21]];
        q.push_back(e);
        pad_in = pin;
        @(posedge clk) #1;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
        if (with_cfg) begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = cdat; end
        @(posedge clk) #1;
        if (with_cfg) begin cfg_we = 1'b0; en_m = cdat & 8'hF8; end
        do @(negedge clk); while (!req_ready);
        @(posedge clk) #1;
        req_valid = 1'b0;
    endtask

    // monitor: records pin activity and compares on each completion
    int n_ale = 0, n_rd = 0, n_wr = 0;
    logic [15:0] a_pins, w_pins;
    logic [1:0]  a_oe, w_oe, r_oe;
    logic [23:0] a_ext, s_ext;
    logic turn_seen = 0, turn_ok = 0, prev_ale = 0, prev_ready = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_ready && req_ready) chk(0, "R11", "ready longer than one clock", 2, 1);
            if (prev_ale && !wr_stb) begin
                turn_seen = 1;
                turn_ok = (pad_oe == 2'b00) && !rd_stb && !ale;
            end
            if (ale) begin n_ale++; a_pins = pad_out; a_oe = pad_oe; a_ext = ext_addr; end
            if (wr_stb) begin n_wr++; w_pins = pad_out; w_oe = pad_oe; s_ext = ext_addr; end
            if (rd_stb) begin n_rd++; r_oe = pad_oe; s_ext = ext_addr; end
            if (req_ready) begin
                exp_t e;
                string rw;
                if (q.size() == 0) chk(0, "R11", "unexpected ready", 1, 0);
                else begin
                    e = q.pop_front();
                    rw = (e.addr[23:21] < 3) ? "R2" : "R3";
                    chk(n_ale == (e.mux ? 1 : 0), rw, "ale count", n_ale, e.mux ? 1 : 0);
                    if (e.mux) begin
                        chk(a_pins == fit(e.wide, e.addr[15:0]), "R7", "address on pads", a_pins, fit(e.wide, e.addr[15:0]));
                        chk(a_oe == (e.wide ? 2'b11 : 2'b01), e.wide ? "R5" : "R4", "address lane enables", a_oe, e.wide ? 2'b11 : 2'b01);
                        chk(a_ext == e.addr, "R6", "ext_addr in address phase", a_ext, e.addr);
                    end
                    chk(turn_seen == (e.mux && !e.write), "R8", "turnaround presence", turn_seen, e.mux && !e.write);
                    if (turn_seen) chk(turn_ok, "R8", "turnaround released", turn_ok, 1);
                    chk(s_ext == e.addr, "R6", "ext_addr in data phase", s_ext, e.addr);
                    if (e.write) begin
                        chk(n_wr == 1 && n_rd == 0, "R9", "write strobes", n_wr, 1);
                        chk(w_pins == fit(e.wide, e.wdata), e.wide ? "R5" : "R9", "write data on pads", w_pins, fit(e.wide, e.wdata));
                        chk(w_oe == (e.wide ? 2'b11 : 2'b01), e.wide ? "R5" : "R4", "write lane enables", w_oe, e.wide ? 2'b11 : 2'b01);
                    end else begin
                        chk(n_rd == 1 && n_wr == 0, "R10", "read strobes", n_rd, 1);
                        chk(r_oe == 2'b00, "R10", "pads released on read", r_oe, 0);
                        chk(rsp_rdata == fit(e.wide, e.pin), "R10", "read data", rsp_rdata, fit(e.wide, e.pin));
                    end
                end
                n_ale = 0; n_rd = 0; n_wr = 0; turn_seen = 0; turn_ok = 0;
            end
            prev_ale = ale;
            prev_ready = req_ready;
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst = 1'b0;
                @(negedge clk);
                chk(!ale && !rd_stb && !wr_stb && !req_ready && pad_oe == 0, "R1", "idle after reset",
                    {ale, rd_stb, wr_stb, req_ready, pad_oe}, 0);
                // R1: registers cleared, area 3 runs plain 8-bit
                access(0, 24'h60_0010, 16'h0, 16'hBEEF, 0, 8'h00);
                cfg_write(0, 8'hFF);          // R2: bits 0..2 must not take effect
                cfg_write(1, 8'b1010_1000);   // areas 3,5,7 wide
                access(1, 24'h61_2345, 16'hA55A, 16'h0, 0, 8'h00);   // R3/R5 wide write
                access(0, 24'h61_2346, 16'h0, 16'hC3D2, 0, 8'h00);   // R5 wide read
                access(1, 24'h80_00F7, 16'h1234, 16'h0, 0, 8'h00);   // R4 narrow write
                access(0, 24'h9A_BC81, 16'h0, 16'hFF7E, 0, 8'h00);   // R4/R10 narrow read
                access(0, 24'h20_0004, 16'h0, 16'h5A5A, 0, 8'h00);   // R2 area 1
                access(1, 24'h00_0100, 16'h8899, 16'h0, 0, 8'h00);   // R2 area 0
                access(0, 24'hC0_FFFF, 16'h0, 16'h0102, 0, 8'h00);   // area 6 narrow
                cfg_write(0, 8'hD8);                                 // disable area 5
                access(0, 24'hA0_0002, 16'h0, 16'h7654, 0, 8'h00);   // R3 plain wide
                access(1, 24'hE0_0042, 16'hCAFE, 16'h0, 1, 8'h00);   // R12 old config
                access(0, 24'hE0_0044, 16'h0, 16'h3141, 0, 8'h00);   // R12 new config
                chk(q.size() == 0, "R11", "scoreboard drained", q.size(), 0);
            end
            begin
                repeat (100000) @(posedge clk);
                chk(0, "R11", "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule